// File: doc/BRIEF.md
# Programmable memory bank address decoder

This block turns a physical byte address into a socket select and a byte offset for a memory subsystem with six module sockets. Every socket holds nothing, an 8 MB module or a 32 MB module. The window a socket answers to comes from one of two sources. In the first, a table of eight end addresses, counted in 8 MB units, places each window, and neighbouring table entries chain the windows together. In the second, the populated modules are packed one after another from address zero.

A requester presents an address with a valid strobe. One clock later the block returns a one-hot socket select, the offset inside the selected module and a miss flag. The configuration inputs are treated as quasi-static: the module size codes, the end-address table and the placement mode. Windows may overlap in table mode, and the higher-numbered socket then takes the access.

Top module: `mem_bank_decoder`

## Requirements
- R1: After a synchronous reset, `rsp_vld`, `rsp_sel`, `rsp_ofs` and `rsp_miss` are all zero until the first accepted request.
- R2: `rsp_vld` is high exactly in the cycle after `req_vld` was high. The result describes the address and configuration sampled on that edge, and all result fields are zero when `rsp_vld` is low.
- R3: The size code of socket s sits in `sock_size[2s+1:2s]`. Code 1 means 8 MB, code 2 means 32 MB, and codes 0 and 3 mean that the socket is empty.
- R4: In table mode (`auto_place`=0), table entry k sits in `end_tbl[5k+4:5k]`. Socket s starts at 0 when s=0 and at entry s otherwise, and its end is entry s+1. Addresses scale by 8 MB per unit, and entries 0 and 7 place no socket.
- R5: In table mode, a socket whose end entry equals its start is disabled and never selected.
- R6: An empty socket is never selected, in either mode and whatever the table holds.
- R7: A socket matches when the address is at or above its window start and the address minus the start is below its module size. `rsp_ofs` is that difference.
- R8: In auto mode (`auto_place`=1) the table is ignored. The populated sockets are placed back to back in ascending socket order from address 0, and each one takes its module size.
- R9: When more than one enabled window matches, the highest-numbered socket is selected.
- R10: When no enabled window matches, `rsp_miss` is 1, `rsp_sel` is 0 and `rsp_ofs` is 0. With `rsp_vld` high, exactly one of a miss or a single select bit holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Address valid strobe |
| req_addr | input | 32 | Physical byte address |
| sock_size | input | 12 | Two-bit size code per socket |
| end_tbl | input | 40 | Eight 5-bit end-address entries in 8 MB units |
| auto_place | input | 1 | 1 = contiguous automatic placement, 0 = table placement |
| rsp_vld | output | 1 | Result valid, one cycle after `req_vld` |
| rsp_sel | output | 6 | One-hot socket select |
| rsp_ofs | output | 25 | Byte offset inside the selected module |
| rsp_miss | output | 1 | No enabled window matched |

## Verification
Every result is due on the clock edge that follows the edge on which the request was sampled. The bench drives an address and configuration on a falling edge and holds them there. The next rising edge captures them, and the bench compares select, offset and miss at the falling edge after that. It also checks that the valid bit and the result fields fall to zero one cycle after the strobe drops.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

    parameter int NSOCK      = 6;
    parameter int NENT       = 8;
    parameter int ENT_W      = 5;
    parameter int ADDR_W     = 32;
    parameter int UNIT_SHIFT = 23;
    parameter int BIG_UNITS  = 4;

    localparam int UNITS_W = $clog2(BIG_UNITS + 1);
    localparam int OFS_W   = UNIT_SHIFT + $clog2(BIG_UNITS);
    localparam int SEL_W   = $clog2(NSOCK);

    typedef enum logic [1:0] {
        SZ_NONE  = 2'd0,
        SZ_SMALL = 2'd1,
        SZ_LARGE = 2'd2,
        SZ_RSVD  = 2'd3
    } size_code_e;

    typedef struct packed {
        logic               en;
        logic [ENT_W-1:0]   start;
        logic [UNITS_W-1:0] units;
    } window_t;

    typedef struct packed {
        logic             hit;
        logic [OFS_W-1:0] ofs;
    } match_t;

    function automatic logic [UNITS_W-1:0] units_of(input logic [1:0] code);
        case (size_code_e'(code))
            SZ_SMALL: units_of = UNITS_W'(1);
            SZ_LARGE: units_of = UNITS_W'(BIG_UNITS);
            default:  units_of = '0;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] to_bytes(input logic [ENT_W:0] u);
        to_bytes = ADDR_W'(u) << UNIT_SHIFT;
    endfunction

endpackage

// File: rtl/mbd_window_gen.sv
module mbd_window_gen
    import mbd_pkg::*;
(
    input  logic [2*NSOCK-1:0]    sock_size,
    input  logic [NENT*ENT_W-1:0] end_tbl,
    input  logic                  auto_place,
    output window_t [NSOCK-1:0]   win
);
    logic [NSOCK-1:0][UNITS_W-1:0] units;
    logic [NSOCK-1:0][ENT_W-1:0]   auto_start;

    // Auto placement: prefix sum of the sizes of lower sockets.
    always_comb begin
        logic [ENT_W-1:0] acc;
        acc = '0;
        for (int s = 0; s < NSOCK; s++) begin
            units[s]      = units_of(sock_size[2*s +: 2]);
            auto_start[s] = acc;
            acc           = acc + ENT_W'(units[s]);
        end
    end

    for (genvar s = 0; s < NSOCK; s++) begin : g_win
        logic [ENT_W-1:0] tbl_start;
        logic [ENT_W-1:0] tbl_end;
        logic             present;

        if (s == 0) begin : g_first
            assign tbl_start = '0;
        end else begin : g_rest
            assign tbl_start = end_tbl[s*ENT_W +: ENT_W];
        end
        assign tbl_end = end_tbl[(s+1)*ENT_W +: ENT_W];
        assign present = (units[s] != '0);

        always_comb begin
            win[s].units = units[s];
            if (auto_place) begin
                win[s].start = auto_start[s];
                win[s].en    = present;
            end else begin
                win[s].start = tbl_start;
                win[s].en    = present && (tbl_end != tbl_start);
            end
        end
    end

endmodule

// File: rtl/mbd_socket_match.sv
module mbd_socket_match
    import mbd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  window_t           win,
    output match_t            m
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
    logic [ADDR_W-1:0] diff;

    assign base  = to_bytes({1'b0, win.start});
    assign limit = to_bytes((ENT_W+1)'(win.units));
    assign diff  = addr - base;

    always_comb begin
        m.hit = win.en && (addr >= base) && (diff < limit);
        m.ofs = diff[OFS_W-1:0];
    end

endmodule

// File: rtl/mbd_prio_pick.sv
module mbd_prio_pick
    import mbd_pkg::*;
(
    input  match_t [NSOCK-1:0] m,
    output logic [NSOCK-1:0]   sel,
    output logic [OFS_W-1:0]   ofs,
    output logic               miss
);
    always_comb begin
        logic             any;
        logic [SEL_W-1:0] idx;
        any = 1'b0;
        idx = '0;
        // Ascending scan: a later (higher) socket overrides a lower one.
        for (int s = 0; s < NSOCK; s++) begin
            if (m[s].hit) begin
                any = 1'b1;
                idx = SEL_W'(s);
            end
        end
        sel  = '0;
        ofs  = '0;
        if (any) begin
            sel[idx] = 1'b1;
            ofs      = m[idx].ofs;
        end
        miss = !any;
    end

endmodule

// File: rtl/mem_bank_decoder.sv
module mem_bank_decoder
    import mbd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_vld,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*NSOCK-1:0]    sock_size,
    input  logic [NENT*ENT_W-1:0] end_tbl,
    input  logic                  auto_place,
    output logic                  rsp_vld,
    output logic [NSOCK-1:0]      rsp_sel,
    output logic [OFS_W-1:0]      rsp_ofs,
    output logic                  rsp_miss
);
    window_t [NSOCK-1:0] win;
    match_t  [NSOCK-1:0] mt;
    logic [NSOCK-1:0]    nxt_sel;
    logic [OFS_W-1:0]    nxt_ofs;
    logic                nxt_miss;

    mbd_window_gen u_wgen (
        .sock_size  (sock_size),
        .end_tbl    (end_tbl),
        .auto_place (auto_place),
        .win        (win)
    );

    for (genvar s = 0; s < NSOCK; s++) begin : g_match
        mbd_socket_match u_match (
            .addr (req_addr),
            .win  (win[s]),
            .m    (mt[s])
        );
    end

    mbd_prio_pick u_pick (
        .m    (mt),
        .sel  (nxt_sel),
        .ofs  (nxt_ofs),
        .miss (nxt_miss)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_sel  <= '0;
            rsp_ofs  <= '0;
            rsp_miss <= 1'b0;
        end else begin
            rsp_vld  <= req_vld;
            rsp_sel  <= req_vld ? nxt_sel  : '0;
            rsp_ofs  <= req_vld ? nxt_ofs  : '0;
            rsp_miss <= req_vld ? nxt_miss : 1'b0;
        end
    end

    // R2: the result valid follows the strobe by one cycle
    a_r2_latency: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld);

    a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!rsp_vld && rsp_sel == '0 && !rsp_miss));

    // R10: a valid result is either a miss or exactly one select
    a_r10_excl: assert property (@(posedge clk) disable iff (rst)
        rsp_vld |-> ($onehot0(rsp_sel) && (rsp_miss == (rsp_sel == '0))));

    a_r10_miss_ofs: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_ofs == '0));

    for (genvar s = 0; s < NSOCK; s++) begin : g_chk
        // R6: an empty socket is never selected
        a_r6_empty: assert property (@(posedge clk) disable iff (rst)
            (req_vld && units_of(sock_size[2*s +: 2]) == '0) |=> !rsp_sel[s]);

        // R7: a small module never yields an offset beyond its size
        a_r7_ofs_bound: assert property (@(posedge clk) disable iff (rst)
            (req_vld && sock_size[2*s +: 2] == 2'd1) |=>
            (!rsp_sel[s] || rsp_ofs < (OFS_W'(1) << UNIT_SHIFT)));

        // R9: a higher socket that matches wins over this one
        if (s < NSOCK - 1) begin : g_prio
            a_r9_prio: assert property (@(posedge clk) disable iff (rst)
                (req_vld && mt[NSOCK-1].hit) |=> !rsp_sel[s]);
        end
    end

endmodule

// File: tb/mem_bank_decoder_test.sv
`timescale 1ns/1ps
module mem_bank_decoder_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [31:0] req_addr;
    logic [11:0] sock_size;
    logic [39:0] end_tbl;
    logic        auto_place;
    logic        rsp_vld;
    logic [5:0]  rsp_sel;
    logic [24:0] rsp_ofs;
    logic        rsp_miss;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    localparam logic [31:0] MB8 = 32'h0080_0000;

    always #4 clk = ~clk;

    mem_bank_decoder uut (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
        .sock_size(sock_size), .end_tbl(end_tbl), .auto_place(auto_place),
        .rsp_vld(rsp_vld), .rsp_sel(rsp_sel), .rsp_ofs(rsp_ofs),
        .rsp_miss(rsp_miss)
    );

    logic [5:0]  exp_sel;
    logic [24:0] exp_ofs;
    logic        exp_miss;

    function automatic int units_for(input logic [1:0] c);
        return (c == 2'd1) ? 1 : (c == 2'd2) ? 4 : 0;
    endfunction

    // Expected result from R3..R10
    task automatic compute_expected();
        int acc = 0;
        int win = -1;
        logic [31:0] wofs = '0;
        for (int s = 0; s < 6; s++) begin
            int u = units_for(sock_size[2*s +: 2]);
            int st;
            bit en;
            if (auto_place) begin
                st = acc; en = (u != 0); acc += u;
            end else begin
                st = (s == 0) ? 0 : int'(end_tbl[5*s +: 5]);
                en = (u != 0) && (int'(end_tbl[5*(s+1) +: 5]) != st);
            end
            if (en) begin
                logic [31:0] base = 32'(st) * MB8;
                logic [31:0] lim  = 32'(u) * MB8;
                if (req_addr >= base && (req_addr - base) < lim) begin
                    win = s; wofs = req_addr - base;
                end
            end
        end
        exp_sel = '0; exp_ofs = '0; exp_miss = 1'b1;
        if (win >= 0) begin
            exp_sel[win] = 1'b1; exp_ofs = wofs[24:0]; exp_miss = 1'b0;
        end
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h addr=%0h", req, act, exp, req_addr);
        end
    endtask

    task automatic txn(input string req, input logic [31:0] a);
        @(negedge clk);
        req_vld  = 1'b1;
        req_addr = a;
        compute_expected();
        @(negedge clk);
        check({req, " vld"},  64'(rsp_vld),  64'd1);
        check({req, " sel"},  64'(rsp_sel),  64'(exp_sel));
        check({req, " ofs"},  64'(rsp_ofs),  64'(exp_ofs));
        check({req, " miss"}, 64'(rsp_miss), 64'(exp_miss));
    endtask

    function automatic logic [39:0] mk_tbl(input int e0, e1, e2, e3, e4, e5, e6, e7);
        return {5'(e7), 5'(e6), 5'(e5), 5'(e4), 5'(e3), 5'(e2), 5'(e1), 5'(e0)};
    endfunction

    initial begin
        process p;
        p = process::self();
        fork
            begin
                #1_000_000;
                if (!done) begin
                    checks++; failures++;
                    $display("FAIL watchdog expired");
                    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; req_vld = 1'b0; req_addr = '0;
        sock_size = '0; end_tbl = '0; auto_place = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 vld",  64'(rsp_vld),  64'd0);
        check("R1 sel",  64'(rsp_sel),  64'd0);
        check("R1 ofs",  64'(rsp_ofs),  64'd0);
        check("R1 miss", 64'(rsp_miss), 64'd0);

        // R3/R4/R9: sockets 0,1 large; socket 1 starts at unit 2 (overlap)
        sock_size = {2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 2'd2};
        end_tbl   = mk_tbl(0, 2, 6, 9, 9, 9, 9, 0);
        txn("R9 overlap high wins", 2*MB8 + 5);
        check("R9 picks socket1", 64'(rsp_sel), 64'h2);
        check("R7 offset in socket1", 64'(rsp_ofs), 64'd5);
        txn("R4 socket0 low", MB8);
        check("R4 socket0 selected", 64'(rsp_sel), 64'h1);
        txn("R7 socket1 last byte", 6*MB8 - 1);
        txn("R7 socket1 past end", 6*MB8);
        check("R10 miss past end", 64'(rsp_miss), 64'd1);

        // R5: socket 1 end equals its start -> disabled
        end_tbl = mk_tbl(0, 2, 2, 9, 9, 9, 9, 0);
        txn("R5 zero window", 2*MB8 + 5);
        check("R5 falls to socket0", 64'(rsp_sel), 64'h1);

        // R6: empty sockets with a table that would place them
        sock_size = {2'd0, 2'd0, 2'd3, 2'd3, 2'd1, 2'd1};
        end_tbl   = mk_tbl(0, 1, 2, 5, 8, 12, 16, 0);
        txn("R6 empty socket2", 3*MB8);
        check("R6 empty miss", 64'(rsp_miss), 64'd1);
        txn("R3 small socket1", MB8 + 7);
        check("R3 small socket1 sel", 64'(rsp_sel), 64'h2);

        // R8: auto placement, table zeroed
        auto_place = 1'b1;
        sock_size  = {2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2};
        end_tbl    = '0;
        txn("R8 auto socket3", 9*MB8 + 1);
        check("R8 auto socket3 sel", 64'(rsp_sel), 64'h8);
        check("R8 auto socket3 ofs", 64'(rsp_ofs), 64'd1);
        txn("R8 auto beyond", 10*MB8);
        check("R8 auto miss", 64'(rsp_miss), 64'd1);
        txn("R8 auto socket1", 4*MB8);
        end_tbl = mk_tbl(31, 3, 3, 3, 3, 3, 3, 31);
        txn("R8 table ignored", 4*MB8);
        check("R8 table ignored sel", 64'(rsp_sel), 64'h2);

        // R2: strobe low -> result cleared one cycle later
        @(negedge clk);
        req_vld = 1'b0;
        @(negedge clk);
        check("R2 vld drops", 64'(rsp_vld), 64'd0);
        check("R2 sel cleared", 64'(rsp_sel), 64'd0);
        check("R2 miss cleared", 64'(rsp_miss), 64'd0);

        // Random legal configurations and addresses
        for (int n = 0; n < 300; n++) begin
            logic [1:0] c;
            int e;
            auto_place = ($urandom % 3) == 0;
            for (int pr = 0; pr < 3; pr++) begin
                c = 2'($urandom % 3);
                sock_size[4*pr +: 4] = {c, c};
            end
            e = 0;
            for (int k = 0; k < 8; k++) begin
                if ($urandom % 4 == 0) e = $urandom % 32;
                else e = (e + ($urandom % 5)) % 32;
                end_tbl[5*k +: 5] = 5'(e);
            end
            for (int t = 0; t < 8; t++) begin
                logic [31:0] a;
                a = 32'($urandom % 32) * MB8;
                case ($urandom % 4)
                    0: a = a - 1;
                    1: a = a + 1;
                    2: a = a + ($urandom % (4*MB8));
                    default: ;
                endcase
                txn("R7 R9 R10 random", a);
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule